// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for each received frame, whether the frame is kept or dropped, looking only at the frame's 48-bit destination address. An upstream parser presents the address together with a one-cycle strobe. One clock later the block returns a registered keep/drop decision. The decision draws on three sources. The first is a bank of eight exact-match address slots. The second is a 64-bin multicast hash table whose index folds all 48 address bits into 6 bits by XOR. The third is a set of mode bits: accept everything, accept all multicast, drop broadcast, and enable the hash lookup.

A simple word-wide write port programs the slots, the two 32-bit halves of the hash table, the mode bits and the count of slots reserved for unicast addresses. Slots below the reserved count compare only against unicast destinations. Slots at or above the count compare only against multicast destinations. Slot 0 normally holds the station's own address. Frame parsing, checksum handling and statistics belong to other blocks.

The destination address port carries byte 0 of the address (the first byte on the wire) in bits 7:0 and byte 5 in bits 47:40. Address bit k is port bit k.

Top module: `rxaf_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are 0. All slots are disabled, both hash words are 0, the reserved count is 1 and only the hash-enable mode bit is set, so any address is rejected.
- R2: A slot is programmed through two words. The low word (register address 2*i) holds address bits 31:0, with byte 0 in bits 7:0. The high word (address 2*i+1) holds address bits 47:32 in its bits 15:0, with byte 4 in bits 7:0. An enabled slot matches only when all 48 bits are equal.
- R3: A write to a slot's low word disables that slot, and a write to its high word enables it. A slot disabled this way never matches, even if it holds the frame's address.
- R4: An address is multicast when its bit 0 (the lowest bit of byte 0) is 1. Slot i with i below the reserved count matches only unicast addresses. Slot i at or above the count matches only multicast addresses.
- R5: The reserved count is written at register address 19 from the write data. A written value above 8 is ignored and the previous count stays.
- R6: The hash index bit j is the XOR of all address bits k with k mod 6 = j. Indices 0 to 31 select that bit of the low hash word (address 16). Indices 32 to 63 select bit (index-32) of the high hash word (address 17). A set bin accepts a multicast frame.
- R7: Only multicast addresses consult the hash table, and only while hash-enable (mode bit 3) is 1. A unicast address that matches no slot is rejected even with all bins set.
- R8: With all-multicast (mode bit 1) and hash-enable both set, every multicast address is accepted whatever the hash words hold.
- R9: With promiscuous mode (mode bit 0) set, every frame is accepted, including broadcast while drop-broadcast is set.
- R10: With drop-broadcast (mode bit 2) set and promiscuous clear, the all-ones address is rejected even when a hash bin or all-multicast would accept it. The mode register is at address 18.
- R11: `dec_valid` is 1 exactly in the cycle after a cycle with `da_valid` high and carries that frame's decision. Back-to-back strobes give back-to-back decisions. `dec_accept` is 0 whenever `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 5 | Configuration register address |
| wr_data | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address present this cycle |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Decision valid, one cycle after da_valid |
| dec_accept | output | 1 | 1 keeps the frame, 0 drops it |

## Verification
The hardest condition to reach from the ports is a hash bin hit in each half of the table. The bin for an address is not apparent from its bytes. The bench therefore computes the index of several addresses with its own octet-walking hash routine. It programs a single bit in the word that the index selects and expects acceptance. It then moves that bit to the same position in the other word and expects rejection. A second hard condition is the reserved-count boundary. Slots holding a unicast address in the multicast region, and count changes to 0 and to 8, show each slot switching between address classes.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  localparam int RXAF_DA_W   = 48;
  localparam int RXAF_HASH_W = 6;
  localparam int RXAF_WORD_W = 32;

  typedef struct packed {
    logic hash_en;
    logic no_bcast;
    logic all_mcast;
    logic promisc;
  } rxaf_mode_t;

  localparam rxaf_mode_t RXAF_MODE_RST = '{hash_en: 1'b1, no_bcast: 1'b0,
                                           all_mcast: 1'b0, promisc: 1'b0};

  // Fold every address bit k into hash bit (k mod HASH_W).
  function automatic logic [RXAF_HASH_W-1:0] rxaf_fold(input logic [RXAF_DA_W-1:0] a);
    logic [RXAF_HASH_W-1:0] h;
    h = '0;
    for (int k = 0; k < RXAF_DA_W; k++) begin
      h[k % RXAF_HASH_W] = h[k % RXAF_HASH_W] ^ a[k];
    end
    return h;
  endfunction

  function automatic logic rxaf_is_mcast(input logic [RXAF_DA_W-1:0] a);
    return a[0];
  endfunction

endpackage

// File: rtl/rxaf_cfg_regs.sv
module rxaf_cfg_regs
  import rxaf_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int REG_AW = 5,
  parameter int CNT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [REG_AW-1:0]      wr_addr,
  input  logic [RXAF_WORD_W-1:0] wr_data,
  output logic [RXAF_WORD_W-1:0] hash_lo,
  output logic [RXAF_WORD_W-1:0] hash_hi,
  output rxaf_mode_t             mode,
  output logic [CNT_W-1:0]       ucnt
);
  localparam logic [REG_AW-1:0] A_HLO  = REG_AW'(2 * NSLOT);
  localparam logic [REG_AW-1:0] A_HHI  = REG_AW'(2 * NSLOT + 1);
  localparam logic [REG_AW-1:0] A_MODE = REG_AW'(2 * NSLOT + 2);
  localparam logic [REG_AW-1:0] A_CNT  = REG_AW'(2 * NSLOT + 3);

  logic wr_cnt, cnt_legal;
  assign wr_cnt    = wr_en && (wr_addr == A_CNT);
  assign cnt_legal = (wr_data <= RXAF_WORD_W'(NSLOT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hash_lo <= '0;
      hash_hi <= '0;
      mode    <= RXAF_MODE_RST;
      ucnt    <= CNT_W'(1);
    end else if (wr_en) begin
      if (wr_addr == A_HLO)  hash_lo <= wr_data;
      if (wr_addr == A_HHI)  hash_hi <= wr_data;
      if (wr_addr == A_MODE) mode    <= rxaf_mode_t'(wr_data[3:0]);
      if (wr_cnt && cnt_legal) ucnt <= wr_data[CNT_W-1:0];
    end
  end

  a_r5_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !cnt_legal) |=> $stable(ucnt));
  a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    ucnt <= CNT_W'(NSLOT));

endmodule

// File: rtl/rxaf_slot_bank.sv
module rxaf_slot_bank
  import rxaf_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int REG_AW = 5,
  parameter int CNT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [REG_AW-1:0]      wr_addr,
  input  logic [RXAF_WORD_W-1:0] wr_data,
  input  logic [CNT_W-1:0]       ucnt,
  input  logic [RXAF_DA_W-1:0]   da,
  output logic                   exact_hit
);
  localparam int HI_W = RXAF_DA_W - RXAF_WORD_W;

  logic [NSLOT-1:0] slot_match;
  logic [NSLOT-1:0] wr_lo, wr_hi;
  logic             da_mcast;

  assign da_mcast = rxaf_is_mcast(da);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [RXAF_WORD_W-1:0] lo_q;
    logic [HI_W-1:0]        hi_q;
    logic                   en_q;
    logic                   mcast_region;

    assign wr_lo[i] = wr_en && (wr_addr == REG_AW'(2 * i));
    assign wr_hi[i] = wr_en && (wr_addr == REG_AW'(2 * i + 1));
    assign mcast_region = (CNT_W'(i) >= ucnt);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
        en_q <= 1'b0;
      end else if (wr_lo[i]) begin
        lo_q <= wr_data;
        en_q <= 1'b0;
      end else if (wr_hi[i]) begin
        hi_q <= wr_data[HI_W-1:0];
        en_q <= 1'b1;
      end
    end

    assign slot_match[i] = en_q && ({hi_q, lo_q} == da) && (mcast_region == da_mcast);

    a_r3_low_write_disables: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo[i] |=> !slot_match[i]);
  end

  assign exact_hit = |slot_match;

endmodule

// File: rtl/rxaf_hash_lookup.sv
module rxaf_hash_lookup
  import rxaf_pkg::*;
(
  input  logic [RXAF_DA_W-1:0]   da,
  input  logic                   hash_en,
  input  logic                   all_mcast,
  input  logic [RXAF_WORD_W-1:0] hash_lo,
  input  logic [RXAF_WORD_W-1:0] hash_hi,
  output logic                   hash_hit
);
  localparam int NBIN = 2 ** RXAF_HASH_W;

  logic [RXAF_HASH_W-1:0] bin_idx;
  logic [NBIN-1:0]        table_bits;
  logic                   is_mcast;

  assign bin_idx    = rxaf_fold(da);
  assign table_bits = all_mcast ? {NBIN{1'b1}} : {hash_hi, hash_lo};
  assign is_mcast   = rxaf_is_mcast(da);
  assign hash_hit   = is_mcast && hash_en && table_bits[bin_idx];

  always_comb begin
    if (hash_hit) begin
      a_r7_hash_mcast_only: assert (da[0] && hash_en);
    end
  end

endmodule

// File: rtl/rxaf_filter.sv
module rxaf_filter
  import rxaf_pkg::*;
#(
  parameter int NSLOT = 8,
  localparam int REG_AW = $clog2(2 * NSLOT + 4),
  localparam int CNT_W  = $clog2(NSLOT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [REG_AW-1:0]      wr_addr,
  input  logic [RXAF_WORD_W-1:0] wr_data,
  input  logic                   da_valid,
  input  logic [RXAF_DA_W-1:0]   da,
  output logic                   dec_valid,
  output logic                   dec_accept
);
  logic [RXAF_WORD_W-1:0] hash_lo, hash_hi;
  rxaf_mode_t             mode;
  logic [CNT_W-1:0]       ucnt;
  logic                   exact_hit, hash_hit, is_bcast, is_mcast, accept_c;

  rxaf_cfg_regs #(.NSLOT(NSLOT), .REG_AW(REG_AW), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hash_lo(hash_lo), .hash_hi(hash_hi), .mode(mode), .ucnt(ucnt)
  );

  rxaf_slot_bank #(.NSLOT(NSLOT), .REG_AW(REG_AW), .CNT_W(CNT_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ucnt(ucnt), .da(da), .exact_hit(exact_hit)
  );

  rxaf_hash_lookup u_hash (
    .da(da), .hash_en(mode.hash_en), .all_mcast(mode.all_mcast),
    .hash_lo(hash_lo), .hash_hi(hash_hi), .hash_hit(hash_hit)
  );

  assign is_bcast = &da;
  assign is_mcast = rxaf_is_mcast(da);
  assign accept_c = mode.promisc ||
                    (!(is_bcast && mode.no_bcast) && (exact_hit || hash_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= da_valid;
      dec_accept <= da_valid && accept_c;
    end
  end

  a_r11_decision_follows: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> dec_valid);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> (!dec_valid && !dec_accept));
  a_r9_promisc_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && mode.promisc) |=> dec_accept);
  a_r10_bcast_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && is_bcast && mode.no_bcast && !mode.promisc) |=> !dec_accept);
  a_r7_unicast_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !is_mcast && !exact_hit && !mode.promisc) |=> !dec_accept);

endmodule

// File: tb/tb_rxaf_filter.sv
module tb_rxaf_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        da_valid = 1'b0;
  logic [47:0] da = '0;
  logic        dec_valid, dec_accept;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rxaf_filter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .da_valid(da_valid), .da(da), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  localparam logic [47:0] STA  = 48'h6655_4433_2210;  // unicast
  localparam logic [47:0] UC1  = 48'h0A0B_0C0D_0E02;  // unicast
  localparam logic [47:0] MC2  = 48'h1122_3344_5501;  // multicast
  localparam logic [47:0] UC3  = 48'h1234_5678_9A00;  // unicast, placed in multicast region
  localparam logic [47:0] BCST = 48'hFFFF_FFFF_FFFF;

  // {expected accept, address}; slots 0..3 loaded, reserved count 2, hash words 0.
  localparam logic [48:0] VECS [8] = '{
    {1'b1, STA},                 // R2 station address in slot 0
    {1'b1, UC1},                 // R4 unicast in reserved slot 1
    {1'b1, MC2},                 // R4 multicast in slot 2
    {1'b0, UC3},                 // R4 unicast sitting in multicast region
    {1'b0, 48'h6755_4433_2210},  // R2 byte 5 differs
    {1'b0, 48'h6655_4433_2211},  // R7 multicast, empty table
    {1'b0, BCST},                // R6 broadcast, empty table
    {1'b0, 48'h0000_0000_0000}   // R3 unprogrammed slots hold zero but stay disabled
  };

  // Bench hash: walk octets LSB first with a wrapping position counter.
  function automatic int ref_bin(input logic [47:0] a);
    int h = 0;
    int pos = 0;
    for (int oc = 0; oc < 6; oc++) begin
      logic [7:0] byt;
      byt = a[oc*8 +: 8];
      for (int b = 0; b < 8; b++) begin
        h = h ^ (int'(byt[b]) << pos);
        pos = (pos == 5) ? 0 : pos + 1;
      end
    end
    return h;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_slot(input int s, input logic [47:0] a);
    wr(2 * s, a[31:0]);
    wr(2 * s + 1, {16'h0, a[47:32]});
  endtask

  task automatic send(input logic [47:0] a, input logic exp, input string tag);
    @(negedge clk);
    da_valid = 1'b1; da = a;
    @(negedge clk);
    da_valid = 1'b0;
    check(dec_valid, 1'b1, {tag, " valid"});
    check(dec_accept, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dec_valid, 1'b0, "R1 reset dec_valid");
    check(dec_accept, 1'b0, "R1 reset dec_accept");
    send(48'h0, 1'b0, "R1 zero address, slots disabled");
    send(BCST, 1'b0, "R1 broadcast, empty table");

    wr(19, 32'd2);
    load_slot(0, STA);
    load_slot(1, UC1);
    load_slot(2, MC2);
    load_slot(3, UC3);
    for (int v = 0; v < 8; v++) begin
      send(VECS[v][47:0], VECS[v][48], $sformatf("table vector %0d", v));
    end

    // R11 back-to-back and idle
    @(negedge clk); da_valid = 1'b1; da = STA;
    @(negedge clk); da = UC3;
    check(dec_valid, 1'b1, "R11 first of pair valid");
    check(dec_accept, 1'b1, "R11 first of pair accept");
    @(negedge clk); da_valid = 1'b0;
    check(dec_valid, 1'b1, "R11 second of pair valid");
    check(dec_accept, 1'b0, "R11 second of pair reject");
    @(negedge clk);
    check(dec_valid, 1'b0, "R11 idle after pair");
    check(dec_accept, 1'b0, "R11 idle accept low");

    // R3 low write disables, high write re-enables
    wr(0, STA[31:0]);
    send(STA, 1'b0, "R3 slot 0 disabled after low write");
    wr(1, {16'h0, STA[47:32]});
    send(STA, 1'b1, "R3 slot 0 enabled after high write");

    // R5 illegal counts ignored, R4 boundaries
    wr(19, 32'd9);
    send(UC1, 1'b1, "R5 count 9 ignored");
    send(MC2, 1'b1, "R5 count 9 ignored, mcast slot");
    wr(19, 32'hFFFF_0001);
    send(MC2, 1'b1, "R5 large count ignored");
    wr(19, 32'd0);
    send(STA, 1'b0, "R4 count 0 makes slot 0 multicast-only");
    send(UC3, 1'b0, "R4 count 0 unicast in slot 3 still rejected");
    wr(19, 32'd8);
    send(MC2, 1'b0, "R4 count 8 makes slot 2 unicast-only");
    send(UC3, 1'b1, "R4 count 8 unicast in slot 3 accepted");
    wr(19, 32'd2);

    // R6 hash bins in both halves
    for (int n = 0; n < 8; n++) begin
      logic [47:0] a;
      int h;
      a = {8'(n * 37 + 5), 8'(n * 91), 8'(n ^ 8'h5A), 8'(n * 13), 8'(n << 3), 8'(8'h01 | (n << 2))};
      h = ref_bin(a);
      if (h < 32) begin
        wr(16, 32'(1) << h); wr(17, 32'h0);
        send(a, 1'b1, $sformatf("R6 bin %0d low word", h));
        wr(16, 32'h0); wr(17, 32'(1) << h);
        send(a, 1'b0, $sformatf("R6 bin %0d wrong word", h));
      end else begin
        wr(16, 32'h0); wr(17, 32'(1) << (h - 32));
        send(a, 1'b1, $sformatf("R6 bin %0d high word", h));
        wr(16, 32'(1) << (h - 32)); wr(17, 32'h0);
        send(a, 1'b0, $sformatf("R6 bin %0d wrong word", h));
      end
    end

    // R7 unicast ignores table, hash-enable gates it
    wr(16, 32'hFFFF_FFFF); wr(17, 32'hFFFF_FFFF);
    send(48'h0102_0304_0506, 1'b0, "R7 unicast with full table");
    send(48'h0102_0304_0507, 1'b1, "R7 multicast with full table");
    wr(18, 32'h0);
    send(48'h0102_0304_0507, 1'b0, "R7 hash disabled");
    send(MC2, 1'b1, "R7 exact slot still works without hash");
    wr(16, 32'h0); wr(17, 32'h0);

    // R8 all-multicast
    wr(18, 32'hA);
    send(48'h7777_7777_7777, 1'b1, "R8 all-multicast accepts");
    send(48'h7777_7777_7776, 1'b0, "R8 all-multicast unicast rejected");
    wr(18, 32'h2);
    send(48'h7777_7777_7777, 1'b0, "R8 all-multicast gated by hash enable");

    // R10 broadcast drop
    wr(18, 32'hA);
    send(BCST, 1'b1, "R10 broadcast via all-multicast");
    wr(18, 32'hE);
    send(BCST, 1'b0, "R10 drop-broadcast overrides");
    send(48'h7777_7777_7777, 1'b1, "R10 other multicast still kept");

    // R9 promiscuous
    wr(18, 32'hF);
    send(BCST, 1'b1, "R9 promiscuous keeps broadcast");
    send(48'h0000_0000_0002, 1'b1, "R9 promiscuous keeps unknown unicast");
    wr(18, 32'h8);
    send(48'h0000_0000_0002, 1'b0, "R9 promiscuous cleared");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule